// File: doc/BRIEF.md
# Reflected CRC-32 Byte Engine

This block keeps a running 32-bit CRC over a byte stream on a serial control channel. Bytes arrive on a valid/ready input. Each accepted byte advances the checksum register by eight bit steps in one clock, and the raw register is on an output that can be sampled after every byte. The register sits at all ones whenever the engine is disabled, so a new packet starts from the seed when enable is raised.

The register shifts toward bit 0 with the reflected form (0xEDB88320) of the usual CRC-32 generator. Each incoming byte is bit-reversed on entry, so its most significant bit is absorbed first. The output is the raw register and not a finished checksum. The transmitter forms the checksum word as the inverse of the bit-reversed register and sends its top byte first. A receiver that passes the data and the checksum through the same engine ends at a residue that does not depend on the message.

Back-pressure rules: `in_ready_o` follows `en_i`. While the engine is enabled, every byte with `in_valid_i` high is taken at the next rising clock edge. While it is disabled, no byte is taken and a source must hold its byte. Enable and clear are plain control inputs.

Top module: `reflected_crc32_engine`

## Requirements
- R1: After `rst_n` (active low, asynchronous) is released, `crc_o` reads 0xFFFFFFFF.
- R2: While `en_i` is low, `crc_o` reads 0xFFFFFFFF from the next edge on, and a byte presented with `in_valid_i` high has no effect on it.
- R3: `in_ready_o` is high exactly when `en_i` is high.
- R4: A byte is accepted at a rising edge where `in_valid_i` and `in_ready_o` are both high. `crc_o` shows the updated value right after that edge.
- R5: While enabled, on an edge with no accepted byte, `crc_o` keeps its value.
- R6: The update takes in the eight bits in the order `in_data_i[7]` down to `in_data_i[0]`. For each bit b, it computes f = crc[0] xor b, shifts crc right by one, and XORs in 0xEDB88320 when f is 1.
- R7: Form the checksum C = ~bitreverse32(crc_o) after the data, then feed it as C[31:24], C[23:16], C[15:8], C[7:0]. The register then equals one message-independent residue. This includes the message 00 00 00 04 00 00 00 00.
- R8: When `en_i` rises in the same cycle that a byte is presented, that byte is accepted and updates from the seed 0xFFFFFFFF. When `en_i` falls in the same cycle that a byte is presented, the byte is dropped and the register returns to the seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Engine enable; low holds the register at the seed |
| in_valid_i | input | 1 | A byte is presented on `in_data_i` |
| in_ready_o | output | 1 | Engine can take a byte this cycle |
| in_data_i | input | 8 | Byte to absorb |
| crc_o | output | 32 | Raw reflected CRC register |

## Verification
Two pairs of functions can fall in the same cycle. One is a byte write in the cycle enable rises. The other is a byte write in the cycle enable falls. In the first case seeding and update must combine: the byte must update from the seed. In the second case the clear must win and the byte must be lost. The bench provokes both by changing `en_i` and `in_valid_i` together between edges. It judges the result against a bit-serial model started from the seed. The residue check feeds several messages plus their checksums and compares the final register with the residue of the first message and with the model.

// File: rtl/crc_pkg.sv
package crc_pkg;
  localparam int unsigned CRC_W_DEF  = 32;
  localparam int unsigned DATA_W_DEF = 8;
  localparam logic [31:0] POLY_REFL  = 32'hEDB88320;
  localparam logic [31:0] SEED_ONES  = 32'hFFFFFFFF;
endpackage

// File: rtl/crc_bitrev.sv
module crc_bitrev #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] in_i,
  output logic [W-1:0] out_o
);
  for (genvar i = 0; i < W; i++) begin : g_rev
    assign out_o[i] = in_i[W-1-i];
  end
endmodule

// File: rtl/crc_step.sv
module crc_step #(
  parameter int unsigned CRC_W  = 32,
  parameter int unsigned DATA_W = 8,
  parameter logic [CRC_W-1:0] POLY = crc_pkg::POLY_REFL
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CRC_W-1:0]  crc_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [CRC_W-1:0]  crc_o
);
  logic [CRC_W-1:0] stage [DATA_W+1];

  assign stage[0] = crc_i;

  for (genvar k = 0; k < DATA_W; k++) begin : g_bit
    logic fb;
    assign fb = stage[k][0] ^ data_i[k];
    assign stage[k+1] = (stage[k] >> 1) ^ (fb ? POLY : '0);
  end

  assign crc_o = stage[DATA_W];

  // zero state with zero data is a fixed point of a linear update
  p_zero_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((crc_i == '0) && (data_i == '0)) |-> (crc_o == '0));
endmodule

// File: rtl/crc_state_reg.sv
module crc_state_reg #(
  parameter int unsigned CRC_W = 32,
  parameter logic [CRC_W-1:0] SEED = crc_pkg::SEED_ONES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             accept_i,
  input  logic [CRC_W-1:0] next_i,
  output logic [CRC_W-1:0] q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_o <= SEED;
    end else if (!en_i) begin
      q_o <= SEED;
    end else if (accept_i) begin
      q_o <= next_i;
    end
  end

  p_reset_seed_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (q_o == SEED));

  p_seed_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (q_o == SEED));

  p_hold_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !accept_i) |=> $stable(q_o));
endmodule

// File: rtl/reflected_crc32_engine.sv
module reflected_crc32_engine #(
  parameter int unsigned CRC_W      = crc_pkg::CRC_W_DEF,
  parameter int unsigned DATA_W     = crc_pkg::DATA_W_DEF,
  parameter logic [CRC_W-1:0] POLY  = crc_pkg::POLY_REFL,
  parameter logic [CRC_W-1:0] SEED  = crc_pkg::SEED_ONES,
  parameter bit          BIT_REV_IN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] in_data_i,
  output logic [CRC_W-1:0]  crc_o
);
  logic [DATA_W-1:0] ordered;
  logic [CRC_W-1:0]  crc_q;
  logic [CRC_W-1:0]  crc_next;
  logic              accept;

  if (BIT_REV_IN) begin : g_rev_in
    crc_bitrev #(.W(DATA_W)) u_rev (
      .in_i (in_data_i),
      .out_o(ordered)
    );
  end else begin : g_straight_in
    assign ordered = in_data_i;
  end

  assign in_ready_o = en_i;
  assign accept     = in_valid_i & in_ready_o;

  crc_step #(.CRC_W(CRC_W), .DATA_W(DATA_W), .POLY(POLY)) u_step (
    .clk   (clk),
    .rst_n (rst_n),
    .crc_i (crc_q),
    .data_i(ordered),
    .crc_o (crc_next)
  );

  crc_state_reg #(.CRC_W(CRC_W), .SEED(SEED)) u_state (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (en_i),
    .accept_i(accept),
    .next_i  (crc_next),
    .q_o     (crc_q)
  );

  assign crc_o = crc_q;

  // a disabled engine never reports a change away from the seed
  p_off_no_change_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready_o && in_valid_i) |=> (crc_o == SEED));
endmodule

// File: tb/reflected_crc32_engine_tb_top.sv
module reflected_crc32_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        en;
  logic        vld;
  logic        rdy;
  logic [7:0]  dat;
  logic [31:0] crc;

  int unsigned n_cmp = 0;
  int unsigned n_bad = 0;
  logic [31:0] model;
  logic [31:0] residue0;
  logic [15:0] lfsr;

  always #2 clk = ~clk;

  reflected_crc32_engine dut_i (
    .clk(clk), .rst_n(rst_n), .en_i(en), .in_valid_i(vld),
    .in_ready_o(rdy), .in_data_i(dat), .crc_o(crc)
  );

  function automatic logic [31:0] ref_byte(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r = c;
    for (int i = 7; i >= 0; i--) begin
      logic f = r[0] ^ b[i];
      r = r >> 1;
      if (f) r = r ^ 32'hEDB88320;
    end
    return r;
  endfunction

  function automatic logic [31:0] rev32(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[31-i];
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    vld = 1'b1; dat = b;
    @(posedge clk); #1;
    vld = 1'b0;
    model = ref_byte(model, b);
    check("R4", crc, model);
  endtask

  task automatic restart();
    en = 1'b0;
    @(posedge clk); #1;
    check("R2", crc, 32'hFFFFFFFF);
    en = 1'b1;
    model = 32'hFFFFFFFF;
  endtask

  task automatic send_checksum(input string req);
    logic [31:0] c = ~rev32(crc);
    send(c[31:24]); send(c[23:16]); send(c[15:8]); send(c[7:0]);
    check(req, crc, model);
  endtask

  function automatic logic [15:0] step_lfsr(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b1; en = 1'b0; vld = 1'b0; dat = 8'h00;
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1", crc, 32'hFFFFFFFF);
    check("R3", {31'd0, rdy}, 32'd0);

    // R2: writes while disabled are dropped
    vld = 1'b1; dat = 8'h5A;
    repeat (3) @(posedge clk);
    #1 vld = 1'b0;
    check("R2", crc, 32'hFFFFFFFF);

    en = 1'b1; #1;
    check("R3", {31'd0, rdy}, 32'd1);
    model = 32'hFFFFFFFF;

    // R6: every byte value from the seed
    for (int v = 0; v < 256; v++) begin
      send(v[7:0]);
      check("R6", crc, ref_byte(32'hFFFFFFFF, v[7:0]));
      restart();
    end

    // R5: idle cycles hold the value
    send(8'h3C);
    repeat (5) @(posedge clk);
    #1 check("R5", crc, model);

    // R7: stated message and its checksum
    restart();
    send(8'h00); send(8'h00); send(8'h00); send(8'h04);
    send(8'h00); send(8'h00); send(8'h00); send(8'h00);
    send_checksum("R7");
    residue0 = crc;

    // R7: further messages give the same residue
    lfsr = 16'hACE1;
    for (int m = 1; m <= 20; m++) begin
      restart();
      for (int k = 0; k < m * 3; k++) begin
        lfsr = step_lfsr(lfsr);
        send(lfsr[7:0]);
      end
      send_checksum("R7");
      check("R7", crc, residue0);
    end

    // R8: enable rise and byte in the same cycle
    en = 1'b0;
    @(posedge clk); #1;
    en = 1'b1; vld = 1'b1; dat = 8'hA5;
    @(posedge clk); #1;
    vld = 1'b0;
    check("R8", crc, ref_byte(32'hFFFFFFFF, 8'hA5));

    // R8: enable fall and byte in the same cycle
    en = 1'b0; vld = 1'b1; dat = 8'h77;
    @(posedge clk); #1;
    vld = 1'b0;
    check("R8", crc, 32'hFFFFFFFF);
    check("R3", {31'd0, rdy}, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule